// File: doc/BRIEF.md
# Interrupt Pending and Masking Controller

This block collects eight interrupt request sources into one pending field and decides, every cycle, whether the pipeline must take an interrupt exception. Two of the requests belong to software and are set or cleared by register writes. Five come from external pins through a two-flop synchronizer and follow the pin level. One comes from an internal timer/counter request. That last bit is always internal and cannot be given to a pin.

Software reaches two registers through a single read/write port, picked by `reg_sel` (0 = status, 1 = cause). The status register holds a global enable, an exception-level flag and an eight-bit per-source mask. The cause register shows the pending field, holds the two software request bits, and holds a five-bit exception code. When an interrupt is taken, hardware sets the exception-level flag and loads the interrupt code (0) into the code field. While the flag is set, no further interrupt is taken.

Software requests are recognised only after a short internal delay line. This models imprecise recognition: a software request can lag its write by a few cycles. A soft reset clears the external pending bits. A cold reset clears all state.

Top module: `irq_pend_ctl`

## Requirements
- R1: A cause read (`reg_sel`=1) returns the pending field in bits 15:8, laid out as bit 8+0..1 = software requests, bit 8+2..6 = synchronized external pins 0..4, bit 15 = timer request. It returns the code in bits 6:2, and zeros in all other bits.
- R2: An external pin appears in the pending field exactly two clock edges after it is sampled. It follows the pin level, so the pending bit drops two edges after the pin drops.
- R3: `take_irq` is high only when at least one pending bit AND its mask bit (status bit 8+i) is 1. A cleared mask bit blocks that source.
- R4: With the global enable (status bit 0) at 0, `take_irq` stays low whatever is pending.
- R5: While the exception-level flag (status bit 1) is 1, `take_irq` is low. Every clock edge at which `take_irq` is high sets the flag, and this takes priority over a status write in the same cycle.
- R6: The code field (cause bits 6:2, also on `exc_code`) is written by software. At every clock edge where `take_irq` is high it becomes 0, overriding a cause write in the same cycle.
- R7: The software request bits (cause bits 9:8) change only through cause writes, and writing 0 removes a request. Writes to cause bits 15:10 have no effect.
- R8: A software request that is enabled and unmasked raises `take_irq` no later than three clock edges after the write edge.
- R9: A soft reset (`soft_rst_n`=0 at an edge) clears the synchronizer and pending bits 6:2. It leaves the status register, the software bits and the code unchanged.
- R10: A cold reset (`cold_rst_n`=0 at an edge) clears the status register, the software bits, the code, the synchronizer and the software delay line.
- R11: Pending bit 7 equals `timer_irq` in the same cycle. No pin or register write changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous active-low cold reset, clears all state |
| soft_rst_n | input | 1 | Synchronous active-low soft reset, clears external pending state |
| ext_irq | input | 5 | Asynchronous external interrupt pins |
| timer_irq | input | 1 | Internal merged timer / counter-overflow request |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 cause |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| take_irq | output | 1 | Request to take an interrupt exception |
| exc_code | output | 5 | Exception code field of the cause register |

## Verification
The take decision is exercised with the source held masked and then unmasked, with the global enable off while all pins are high, with the exception-level flag set, and separately with a software request, a pin request and a timer request. These patterns separate a missing mask gate, a missing enable gate and a missing exception-level gate, and they show which source path is faulty. Pin edges up and down pin down the synchronizer latency and the level-following behaviour. A software request is accepted at any lag of up to three edges. Soft and cold resets arriving while pins are held high tell the two reset scopes apart.

// File: rtl/irq_pend_pkg.sv
// Package: shared field positions, codes and register select encoding for
// the interrupt pending controller. Assumes a register width of at least 16.
package irq_pend_pkg;

    localparam int NUM_SRC     = 8;
    localparam int NUM_SW      = 2;
    localparam int NUM_EXT     = 5;
    localparam int CODE_W      = 5;

    // pending field slices
    localparam int PEND_SW_LO  = 0;
    localparam int PEND_EXT_LO = 2;
    localparam int PEND_TMR    = 7;

    // status register bit positions
    localparam int ST_EN       = 0;
    localparam int ST_EXL      = 1;
    localparam int ST_MASK_LO  = 8;

    // cause register bit positions
    localparam int CA_CODE_LO  = 2;
    localparam int CA_PEND_LO  = 8;

    localparam logic [CODE_W-1:0] CODE_INTR = '0;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CAUSE  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_sync_chain.sv
// irq_sync_chain: a per-bit shift chain of STAGES flops with a synchronous
// active-low clear. STAGES=0 gives a plain wire. Used both as the pin
// synchronizer and as the software recognition delay line.
// Assumes clr_n is synchronous to clk.
module irq_sync_chain #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_wire
            logic unused_clk;
            assign unused_clk = clk ^ clr_n;
            assign dout = din;
        end else if (STAGES == 1) begin : g_one
            logic [WIDTH-1:0] stage_q;
            // single stage capture
            always_ff @(posedge clk) begin
                if (!clr_n) stage_q <= '0;
                else        stage_q <= din;
            end
            assign dout = stage_q;
        end else begin : g_many
            logic [STAGES-1:0][WIDTH-1:0] stage_q;
            // shift the input along the chain, oldest in the top slot
            always_ff @(posedge clk) begin
                if (!clr_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], din};
            end
            assign dout = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/irq_take_logic.sv
// irq_take_logic: combinational take decision. An interrupt is requested
// when some effective pending bit is unmasked, the global enable is set
// and the exception-level flag is clear. Pure logic, no state.
module irq_take_logic #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] pend_eff,
    input  logic [NSRC-1:0] mask,
    input  logic            glob_en,
    input  logic            exl,
    output logic            take
);

    logic [NSRC-1:0] gated;

    // per-source gate, then reduce
    always_comb begin
        gated = pend_eff & mask;
        take  = glob_en && !exl && (|gated);
    end

endmodule

// File: rtl/irq_csr.sv
// irq_csr: status and cause register state. Holds the global enable, the
// exception-level flag, the mask, the software request bits and the code.
// A hardware take overrides any software write to the flag and the code
// in the same cycle. Assumes DATA_W >= 16.
module irq_csr
    import irq_pend_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              glob_en,
    output logic              exl,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SW-1:0]  sw_req,
    output logic [CODE_W-1:0]  code
);

    logic wr_status;
    logic wr_cause;
    logic unused_wbits;

    assign wr_status = we && (reg_sel_e'(sel) == SEL_STATUS);
    assign wr_cause  = we && (reg_sel_e'(sel) == SEL_CAUSE);
    assign unused_wbits = ^{wdata[DATA_W-1:16], wdata[7]};

    // status register: software write, then hardware sets the flag on a take
    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            glob_en <= 1'b0;
            exl     <= 1'b0;
            mask    <= '0;
        end else begin
            if (wr_status) begin
                glob_en <= wdata[ST_EN];
                exl     <= wdata[ST_EXL];
                mask    <= wdata[ST_MASK_LO +: NUM_SRC];
            end
            if (take) exl <= 1'b1;
        end
    end

    // cause register: software bits and code, code forced on a take
    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            sw_req <= '0;
            code   <= '0;
        end else begin
            if (wr_cause) begin
                sw_req <= wdata[CA_PEND_LO + PEND_SW_LO +: NUM_SW];
                code   <= wdata[CA_CODE_LO +: CODE_W];
            end
            if (take) code <= CODE_INTR;
        end
    end

endmodule

// File: rtl/irq_pend_ctl.sv
// irq_pend_ctl: top of the interrupt pending and masking controller.
// Synchronizes the external pins, delays software requests to model
// imprecise recognition, merges the timer request, and drives the take
// request and the register read mux. Assumes asynchronous pins and an
// internal timer request already in the clk domain.
module irq_pend_ctl
    import irq_pend_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int SW_DELAY    = 2
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              soft_rst_n,
    input  logic [4:0]        ext_irq,
    input  logic              timer_irq,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              take_irq,
    output logic [4:0]        exc_code
);

    localparam int PAD_W = DATA_W - 16;

    logic                 ext_clr_n;
    logic [NUM_EXT-1:0]   ext_sync;
    logic [NUM_SW-1:0]    sw_req;
    logic [NUM_SW-1:0]    sw_eff;
    logic [NUM_SRC-1:0]   pend_vis;
    logic [NUM_SRC-1:0]   pend_eff;
    logic                 st_en;
    logic                 st_exl;
    logic [NUM_SRC-1:0]   st_mask;
    logic [CODE_W-1:0]    ca_code;

    assign ext_clr_n = cold_rst_n && soft_rst_n;

    irq_sync_chain #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk   (clk),
        .clr_n (ext_clr_n),
        .din   (ext_irq),
        .dout  (ext_sync)
    );

    irq_sync_chain #(.WIDTH(NUM_SW), .STAGES(SW_DELAY)) u_sw_delay (
        .clk   (clk),
        .clr_n (cold_rst_n),
        .din   (sw_req),
        .dout  (sw_eff)
    );

    irq_csr #(.DATA_W(DATA_W)) u_csr (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .we         (reg_we),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .take       (take_irq),
        .glob_en    (st_en),
        .exl        (st_exl),
        .mask       (st_mask),
        .sw_req     (sw_req),
        .code       (ca_code)
    );

    // visible pending field and the one used for the take decision
    always_comb begin
        pend_vis = {timer_irq, ext_sync, sw_req};
        pend_eff = {timer_irq, ext_sync, sw_eff};
    end

    irq_take_logic #(.NSRC(NUM_SRC)) u_take (
        .pend_eff (pend_eff),
        .mask     (st_mask),
        .glob_en  (st_en),
        .exl      (st_exl),
        .take     (take_irq)
    );

    // read mux over the two registers
    always_comb begin
        if (reg_sel_e'(reg_sel) == SEL_CAUSE)
            reg_rdata = {{PAD_W{1'b0}}, pend_vis, 1'b0, ca_code, 2'b00};
        else
            reg_rdata = {{PAD_W{1'b0}}, st_mask, 6'b0, st_exl, st_en};
    end

    assign exc_code = ca_code;

endmodule

// File: rtl/irq_pend_ctl_chk.sv
// irq_pend_ctl_chk: temporal checks on the controller, attached by bind.
// Observes ports and the internal register and pending signals.
module irq_pend_ctl_chk (
    input logic       clk,
    input logic       cold_rst_n,
    input logic       soft_rst_n,
    input logic       timer_irq,
    input logic       reg_we,
    input logic       reg_sel,
    input logic       take_irq,
    input logic [4:0] exc_code,
    input logic       st_en,
    input logic       st_exl,
    input logic [7:0] st_mask,
    input logic [7:0] pend_vis,
    input logic [7:0] pend_eff
);

    p_mask_gate_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        take_irq |-> (|(pend_eff & st_mask)));

    p_enable_gate_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        take_irq |-> st_en);

    p_exl_block_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
        st_exl |-> !take_irq);

    p_exl_set_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
        take_irq |=> st_exl);

    p_code_int_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        take_irq |=> (exc_code == 5'd0));

    p_sw_hold_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !(reg_we && reg_sel) |=> (pend_vis[1:0] == $past(pend_vis[1:0])));

    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !soft_rst_n |=> (pend_vis[6:2] == 5'd0));

    p_timer_bit_r11: assert property (@(posedge clk) disable iff (!cold_rst_n)
        pend_vis[7] == timer_irq);

endmodule

bind irq_pend_ctl irq_pend_ctl_chk u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .soft_rst_n (soft_rst_n),
    .timer_irq  (timer_irq),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .take_irq   (take_irq),
    .exc_code   (exc_code),
    .st_en      (st_en),
    .st_exl     (st_exl),
    .st_mask    (st_mask),
    .pend_vis   (pend_vis),
    .pend_eff   (pend_eff)
);

// File: tb/irq_pend_ctl_tb_top.sv
// Bench: behavioural per-cycle model compared on every falling edge, plus
// directed checks. Inputs change just after rising edges.
module irq_pend_ctl_tb_top;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic [4:0]  ext_irq = '0;
    logic        timer_irq = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        take_irq;
    logic [4:0]  exc_code;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_pend_ctl dut_i (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .soft_rst_n (soft_rst_n),
        .ext_irq    (ext_irq),
        .timer_irq  (timer_irq),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .take_irq   (take_irq),
        .exc_code   (exc_code)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---- reference model state ----
    logic [4:0] m_s1 = '0, m_s2 = '0;
    logic [1:0] m_sw = '0;
    logic [1:0] hist [4];
    logic       m_en = 0, m_exl = 0;
    logic [7:0] m_mask = '0;
    logic [4:0] m_code = '0;

    initial for (int i = 0; i < 4; i++) hist[i] = '0;

    // model update at each rising edge from the inputs of the ending cycle
    always @(posedge clk) begin
        bit tk;
        tk = take_irq;
        started = 1;
        if (!cold_rst_n) begin
            m_s1 = '0; m_s2 = '0; m_sw = '0; m_en = 0; m_exl = 0;
            m_mask = '0; m_code = '0;
            for (int i = 0; i < 4; i++) hist[i] = '0;
        end else begin
            if (!soft_rst_n) begin m_s2 = '0; m_s1 = '0; end
            else begin m_s2 = m_s1; m_s1 = ext_irq; end
            if (reg_we && !reg_sel) begin
                m_en = reg_wdata[0]; m_exl = reg_wdata[1]; m_mask = reg_wdata[15:8];
            end
            if (reg_we && reg_sel) begin
                m_sw = reg_wdata[9:8]; m_code = reg_wdata[6:2];
            end
            if (tk) begin m_exl = 1; m_code = 5'd0; end
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = m_sw;
        end
    end

    // compare outputs against the model mid-cycle
    always @(negedge clk) begin
        logic [7:0]  pm;
        logic [31:0] er;
        bit ok_take;
        if (started && !done) begin
            pm = {timer_irq, m_s2, m_sw};
            er = reg_sel ? {16'h0, pm, 1'b0, m_code, 2'b00}
                         : {16'h0, m_mask, 6'b0, m_exl, m_en};
            check(reg_rdata === er, reg_sel ? "R1 cause read" : "R5 status read", reg_rdata, er);
            check(exc_code === m_code, "R6 code", {27'h0, exc_code}, {27'h0, m_code});
            ok_take = 0;
            for (int d = 0; d < 4; d++) begin
                if (take_irq === (m_en && !m_exl && |({timer_irq, m_s2, hist[d]} & m_mask)))
                    ok_take = 1;
            end
            check(ok_take, "R3/R8 take", {31'h0, take_irq}, {31'h0, m_en && !m_exl && |(pm & m_mask)});
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        @(posedge clk); #1;
        reg_we = 1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        cyc(3);
        cold_rst_n = 1;
        // R10: reset state
        @(negedge clk);
        check(take_irq == 0, "R10 take after reset", {31'h0, take_irq}, 0);
        check(exc_code == 0, "R10 code after reset", {27'h0, exc_code}, 0);
        check(reg_rdata == 0, "R10 status after reset", reg_rdata, 0);
        cyc(1); reg_sel = 1;
        @(negedge clk);
        check(reg_rdata == 0, "R10 cause after reset", reg_rdata, 0);

        // R3: masked pin does not take, unmasked does
        wr(0, 32'h0000_0001);
        ext_irq = 5'b00001;
        reg_sel = 1;
        cyc(3);
        @(negedge clk);
        check(take_irq == 0, "R3 masked source", {31'h0, take_irq}, 0);
        check(reg_rdata[15:8] == 8'h04, "R2 pin0 pending", {24'h0, reg_rdata[15:8]}, 32'h04);
        wr(0, 32'h0000_0401);
        @(negedge clk);
        check(take_irq == 1, "R3 unmasked source", {31'h0, take_irq}, 1);
        cyc(1); reg_sel = 0;
        @(negedge clk);
        check(take_irq == 0, "R5 exl blocks", {31'h0, take_irq}, 0);
        check(reg_rdata[1] == 1, "R5 exl set", {31'h0, reg_rdata[1]}, 1);

        // R6: code writable, forced to 0 on take
        wr(1, 32'h0000_0028);
        @(negedge clk);
        check(exc_code == 5'h0A, "R6 code write", {27'h0, exc_code}, 32'h0A);
        wr(0, 32'h0000_0401);
        cyc(1);
        @(negedge clk);
        check(exc_code == 5'h00, "R6 code on take", {27'h0, exc_code}, 0);

        // R2: pending follows the pin level down
        ext_irq = '0;
        cyc(3);
        wr(0, 32'h0000_0401);
        reg_sel = 1;
        @(negedge clk);
        check(take_irq == 0, "R2 pin dropped no take", {31'h0, take_irq}, 0);
        check(reg_rdata[15:8] == 8'h00, "R2 pending cleared", {24'h0, reg_rdata[15:8]}, 0);

        // R4: global enable off blocks all
        wr(0, 32'h0000_FF00);
        ext_irq = 5'h1F;
        reg_sel = 1;
        cyc(4);
        @(negedge clk);
        check(take_irq == 0, "R4 enable off", {31'h0, take_irq}, 0);
        check(reg_rdata[15:8] == 8'h7C, "R1 all pins pending", {24'h0, reg_rdata[15:8]}, 32'h7C);
        ext_irq = '0;
        cyc(3);

        // R8: software request recognised within three edges
        wr(0, 32'h0000_0101);
        wr(1, 32'h0000_0100);
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (take_irq) seen = 1;
        end
        check(seen, "R8 sw request taken", {31'h0, seen}, 1);

        // R7: sw cleared by writing 0, upper cause bits ignored
        wr(1, 32'h0000_FC00);
        reg_sel = 1;
        @(negedge clk);
        check(reg_rdata[15:8] == 8'h00, "R7 sw clear, upper ignored", {24'h0, reg_rdata[15:8]}, 0);

        // R11: timer bit live, takes when unmasked
        wr(0, 32'h0000_8001);
        reg_sel = 1;
        timer_irq = 1;
        @(negedge clk);
        check(take_irq == 1, "R11 timer take", {31'h0, take_irq}, 1);
        check(reg_rdata[15] == 1, "R11 timer pending", {31'h0, reg_rdata[15]}, 1);
        cyc(1);
        timer_irq = 0;
        @(negedge clk);
        check(reg_rdata[15] == 0, "R11 timer follows", {31'h0, reg_rdata[15]}, 0);

        // R9: soft reset clears external pending only
        wr(0, 32'h0000_0300);
        wr(1, 32'h0000_0214);
        ext_irq = 5'h15;
        reg_sel = 1;
        cyc(3);
        soft_rst_n = 0;
        cyc(1);
        soft_rst_n = 1;
        @(negedge clk);
        check(reg_rdata[14:10] == 5'h00, "R9 ext cleared", {27'h0, reg_rdata[14:10]}, 0);
        check(reg_rdata[9:8] == 2'b10, "R9 sw kept", {30'h0, reg_rdata[9:8]}, 2);
        check(exc_code == 5'h05, "R9 code kept", {27'h0, exc_code}, 5);
        cyc(1); reg_sel = 0;
        @(negedge clk);
        check(reg_rdata == 32'h0000_0300, "R9 status kept", reg_rdata, 32'h300);

        // R10: cold reset mid-run
        cold_rst_n = 0;
        cyc(1);
        cold_rst_n = 1;
        @(negedge clk);
        check(reg_rdata == 0, "R10 status cold", reg_rdata, 0);
        check(exc_code == 0, "R10 code cold", {27'h0, exc_code}, 0);
        check(take_irq == 0, "R10 take cold", {31'h0, take_irq}, 0);
        cyc(1); reg_sel = 1;
        @(negedge clk);
        check(reg_rdata[9:8] == 2'b00, "R10 sw cold", {30'h0, reg_rdata[9:8]}, 0);
        ext_irq = '0;
        cyc(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule